// File: doc/BRIEF.md
# Host Byte-Lane Word Assembler

This block sits on the host side of a parallel host port. An external processor writes one byte at a time over an 8-bit bus into a small window of byte-addressed registers. The block collects the high and middle bytes in staging registers. When the host writes the low byte, the block commits a 24-bit word into a receive holding register, sets a valid flag and raises a one-cycle transfer pulse toward the core.

The window is four consecutive byte addresses. The lowest of them is a pad lane that always reads as zero, so a host with a 16-bit or 32-bit bus can walk all four addresses as one wide access. Only the bottom 24 bits of such a sequence are kept. The order of the high and middle writes does not matter. The low-byte write must come last, because that write starts the transfer.

The staging bytes are kept after a transfer. A word that differs from the previous one only in its low byte therefore needs a single host write. The core acknowledges each word with a read strobe. If a second word is committed before the first is acknowledged, the old word is replaced and an overrun flag is raised.

Top module: `hbl_word_asm`

## Requirements
- R1: After reset, rx_word is 0, rx_valid, rx_ovr and xfer_pulse are 0, and every staging byte reads back as 0x00.
- R2: A host write (hst_sel=1, hst_wr=1) to address 5 stores the data byte as word bits 23:16 in staging. It causes no transfer and can be read back at address 5.
- R3: A host write to address 6 stores the data byte as word bits 15:8 in staging. It causes no transfer and can be read back at address 6.
- R4: A host write to address 7 commits {staged bits 23:16, staged bits 15:8, written byte} to rx_word on the next clock edge and sets rx_valid at the same edge.
- R5: Writes to address 4, and to addresses 0 to 3, change no staging byte and no output. Host reads of any of these addresses return 0x00.
- R6: Staging bytes keep their values after a transfer. A lone write to address 7 sends a word that carries the previously staged high and middle bytes.
- R7: A core_ack pulse in a cycle with no commit clears rx_valid and rx_ovr at the next clock edge.
- R8: A commit while rx_valid is 1 and core_ack is 0 overwrites rx_word and sets rx_ovr.
- R9: A commit and a core_ack in the same cycle leave rx_valid at 1 and rx_ovr at 0, and rx_word holds the new word.
- R10: hst_rdata is combinational. During a host read (hst_sel=1, hst_rd=1) of address 5, 6 or 7 it shows that staging byte; address 7 returns the last low byte written. When no host read is in progress, hst_rdata is 0x00.
- R11: xfer_pulse is 1 for exactly one cycle per low-byte write, in the cycle right after that write. Writes to any other address never cause a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host bus and core side |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host chip select, active high |
| hst_wr | input | 1 | Host write strobe, one cycle per byte |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 3 | Host byte address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational |
| core_ack | input | 1 | Core read strobe that acknowledges the held word |
| rx_word | output | 24 | Receive holding register |
| rx_valid | output | 1 | Held word not yet acknowledged |
| rx_ovr | output | 1 | A word was overwritten before acknowledge |
| xfer_pulse | output | 1 | One-cycle pulse when a word is committed |

## Verification
Two functions can fall in the same clock cycle: a new commit from the host and an acknowledge from the core. The bench first builds an overrun state with two unacknowledged low-byte writes. It then drives a third low-byte write and core_ack together on one edge. The result is judged against R9: valid stays set, the overrun flag drops, and the scoreboard receives the new word. A separate plain acknowledge then confirms that R7 clears valid.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
    // Default geometry of the host byte window
    localparam int HBL_BYTE_W  = 8;
    localparam int HBL_LANES   = 3;
    localparam int HBL_ADDR_W  = 3;
    localparam int HBL_BASE    = 4;   // pad lane address; data lanes follow it

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_STAGE = 2'd1,
        ACC_COMMIT = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/hbl_lane_decode.sv
module hbl_lane_decode #(
    parameter int ADDR_W = hbl_pkg::HBL_ADDR_W,
    parameter int LANES  = hbl_pkg::HBL_LANES,
    parameter int BASE   = hbl_pkg::HBL_BASE
) (
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  lane_we,
    output logic [LANES-1:0]  lane_re,
    output hbl_pkg::acc_kind_e kind
);
    // lane k lives at BASE+LANES-k: lane 0 (low byte) is the last address
    always_comb begin
        lane_we = '0;
        lane_re = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel && addr == ADDR_W'(BASE + LANES - k)) begin
                lane_we[k] = wr;
                lane_re[k] = rd;
            end
        end
        if (lane_we[0])
            kind = hbl_pkg::ACC_COMMIT;
        else if (|lane_we)
            kind = hbl_pkg::ACC_STAGE;
        else
            kind = hbl_pkg::ACC_IDLE;
    end
endmodule

// File: rtl/hbl_stage.sv
module hbl_stage #(
    parameter int BYTE_W = hbl_pkg::HBL_BYTE_W,
    parameter int LANES  = hbl_pkg::HBL_LANES,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] stage_word,
    output logic [WORD_W-1:0] stage_next
);
    logic [LANES-1:0][BYTE_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < LANES; k++) begin
            if (lane_we[k])
                st_d[k] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stage_word = st_q;
    assign stage_next = st_d;   // includes the low byte being written now
endmodule

// File: rtl/hbl_rx_hold.sv
module hbl_rx_hold #(
    parameter int WORD_W = hbl_pkg::HBL_BYTE_W * hbl_pkg::HBL_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              ack,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              ovr,
    output logic              pulse
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              ovr;
        logic              pulse;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        h_d.pulse = commit;
        if (commit) begin
            h_d.word  = word_in;
            h_d.valid = 1'b1;
            // an acknowledge in the same cycle consumed the old word
            h_d.ovr   = h_q.valid && !ack ? 1'b1 : (ack ? 1'b0 : h_q.ovr);
        end else if (ack) begin
            h_d.valid = 1'b0;
            h_d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            h_q <= '0;
        else
            h_q <= h_d;
    end

    assign word  = h_q.word;
    assign valid = h_q.valid;
    assign ovr   = h_q.ovr;
    assign pulse = h_q.pulse;
endmodule

// File: rtl/hbl_word_asm.sv
module hbl_word_asm #(
    parameter int BYTE_W = hbl_pkg::HBL_BYTE_W,
    parameter int LANES  = hbl_pkg::HBL_LANES,
    parameter int ADDR_W = hbl_pkg::HBL_ADDR_W,
    parameter int BASE   = hbl_pkg::HBL_BASE,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [BYTE_W-1:0] hst_wdata,
    output logic [BYTE_W-1:0] hst_rdata,
    input  logic              core_ack,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_ovr,
    output logic              xfer_pulse
);
    logic [LANES-1:0]   lane_we, lane_re;
    hbl_pkg::acc_kind_e kind;
    logic [WORD_W-1:0]  stage_word, stage_next;
    logic               commit;

    hbl_lane_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .BASE(BASE)) dec_i (
        .sel     (hst_sel),
        .wr      (hst_wr),
        .rd      (hst_rd),
        .addr    (hst_addr),
        .lane_we (lane_we),
        .lane_re (lane_re),
        .kind    (kind)
    );

    hbl_stage #(.BYTE_W(BYTE_W), .LANES(LANES)) stg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_we    (lane_we),
        .wdata      (hst_wdata),
        .stage_word (stage_word),
        .stage_next (stage_next)
    );

    assign commit = (kind == hbl_pkg::ACC_COMMIT);

    hbl_rx_hold #(.WORD_W(WORD_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .ack     (core_ack),
        .word_in (stage_next),
        .word    (rx_word),
        .valid   (rx_valid),
        .ovr     (rx_ovr),
        .pulse   (xfer_pulse)
    );

    // read mux: pad lane and unmapped addresses fall through as zero
    always_comb begin
        hst_rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_re[k])
                hst_rdata = stage_word[k*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/hbl_word_asm_chk.sv
module hbl_word_asm_chk #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 3,
    parameter int ADDR_W = 3,
    parameter int BASE   = 4,
    localparam int WORD_W = BYTE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_sel,
    input logic              hst_wr,
    input logic              hst_rd,
    input logic [ADDR_W-1:0] hst_addr,
    input logic [BYTE_W-1:0] hst_wdata,
    input logic [BYTE_W-1:0] hst_rdata,
    input logic              core_ack,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid,
    input logic              rx_ovr,
    input logic              xfer_pulse
);
    logic low_wr, pad_rd, hi_wr;
    assign low_wr = hst_sel && hst_wr && hst_addr == ADDR_W'(BASE + LANES);
    assign hi_wr  = hst_sel && hst_wr && hst_addr == ADDR_W'(BASE + 1);
    assign pad_rd = hst_sel && hst_rd && hst_addr == ADDR_W'(BASE);

    a_r4_commit_word: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr |=> rx_valid && rx_word[BYTE_W-1:0] == $past(hst_wdata));

    a_r11_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_pulse |-> $past(low_wr));

    a_r11_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr |=> xfer_pulse);

    a_r2_high_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> !xfer_pulse);

    a_r5_pad_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pad_rd |-> hst_rdata == '0);

    a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_pulse |-> $stable(rx_word));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack && !low_wr |=> !rx_valid && !rx_ovr);

    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr && rx_valid && !core_ack |=> rx_ovr);

    a_r9_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr && core_ack |=> rx_valid && !rx_ovr);

    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_sel && hst_rd) |-> hst_rdata == '0);
endmodule

bind hbl_word_asm hbl_word_asm_chk #(
    .BYTE_W(BYTE_W), .LANES(LANES), .ADDR_W(ADDR_W), .BASE(BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
    .hst_rd(hst_rd), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .core_ack(core_ack), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_ovr(rx_ovr), .xfer_pulse(xfer_pulse)
);

// File: tb/hbl_word_asm_tb_top.sv
module hbl_word_asm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel = 1'b0, hst_wr = 1'b0, hst_rd = 1'b0;
    logic [2:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        core_ack = 1'b0;
    logic [23:0] rx_word;
    logic        rx_valid, rx_ovr, xfer_pulse;

    int n_run = 0, n_fail = 0;
    int pulses_seen = 0, low_writes = 0;
    bit done = 0;
    logic [7:0]  mdl [5:7];
    logic [23:0] exp_q [$];

    always #4 clk = ~clk;   // 125 MHz

    hbl_word_asm dut_i (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_rd(hst_rd), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .core_ack(core_ack), .rx_word(rx_word),
        .rx_valid(rx_valid), .rx_ovr(rx_ovr), .xfer_pulse(xfer_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one host write, optionally with a core acknowledge on the same edge
    task automatic host_write(input logic [2:0] a, input logic [7:0] d, input bit ack);
        @(negedge clk);
        hst_sel = 1; hst_wr = 1; hst_addr = a; hst_wdata = d; core_ack = ack;
        if (a >= 5) mdl[a] = d;
        if (a == 7) begin
            exp_q.push_back({mdl[5], mdl[6], mdl[7]});
            low_writes++;
        end
        @(posedge clk);
        @(negedge clk);
        hst_sel = 0; hst_wr = 0; core_ack = 0;
    endtask

    task automatic core_acknowledge();
        @(negedge clk);
        core_ack = 1;
        @(negedge clk);
        core_ack = 0;
    endtask

    task automatic host_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        hst_sel = 1; hst_rd = 1; hst_addr = a;
        #1;
        check(hst_rdata == exp, req, 32'(hst_rdata), 32'(exp));
        hst_sel = 0; hst_rd = 0;
        #1;
        check(hst_rdata == 8'h00, "R10 idle rdata", 32'(hst_rdata), 32'h0);
    endtask

    // monitor: pop the scoreboard on each transfer pulse (R4, R11)
    always @(negedge clk) begin
        if (rst_n && xfer_pulse) begin
            pulses_seen++;
            if (exp_q.size() == 0)
                check(1'b0, "R11 unexpected pulse", 32'(rx_word), 32'h0);
            else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(rx_word == e, "R4 committed word", 32'(rx_word), 32'(e));
                check(rx_valid == 1'b1, "R4 valid set", 32'(rx_valid), 32'h1);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 5; i <= 7; i++) mdl[i] = 8'h00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(rx_word == 24'h0, "R1 rx_word", 32'(rx_word), 32'h0);
        check(!rx_valid && !rx_ovr && !xfer_pulse, "R1 flags",
              {29'h0, rx_valid, rx_ovr, xfer_pulse}, 32'h0);
        for (int a = 5; a <= 7; a++) host_read(3'(a), 8'h00, "R1 staging zero");

        // R2, R3 staging writes with readback and no transfer
        host_write(3'd5, 8'hA1, 0);
        check(!xfer_pulse, "R2 no pulse", 32'(xfer_pulse), 32'h0);
        host_write(3'd6, 8'hB2, 0);
        check(!xfer_pulse && !rx_valid, "R3 no pulse", {30'h0, xfer_pulse, rx_valid}, 32'h0);
        host_read(3'd5, 8'hA1, "R2 readback");
        host_read(3'd6, 8'hB2, "R3 readback");

        // R5 pad lane and unmapped addresses ignored, read zero
        host_write(3'd4, 8'hFF, 0);
        host_write(3'd1, 8'h5A, 0);
        check(!rx_valid && rx_word == 24'h0, "R5 no output change", 32'(rx_word), 32'h0);
        host_read(3'd4, 8'h00, "R5 pad read");
        for (int a = 0; a < 4; a++) host_read(3'(a), 8'h00, "R5 unmapped read");
        host_read(3'd5, 8'hA1, "R5 staging unchanged");
        host_read(3'd6, 8'hB2, "R5 staging unchanged");

        // R4 commit
        host_write(3'd7, 8'hC3, 0);
        check(rx_word == 24'hA1B2C3, "R4 word", 32'(rx_word), 32'hA1B2C3);
        @(negedge clk);
        check(!xfer_pulse, "R11 single-cycle pulse", 32'(xfer_pulse), 32'h0);
        host_read(3'd7, 8'hC3, "R10 low readback");

        // R8 overrun
        host_write(3'd7, 8'hD4, 0);
        check(rx_ovr == 1'b1, "R8 overrun set", 32'(rx_ovr), 32'h1);
        check(rx_word == 24'hA1B2D4, "R8 overwrite", 32'(rx_word), 32'hA1B2D4);

        // R9 commit and ack in the same cycle
        host_write(3'd7, 8'hE5, 1);
        check(rx_valid && !rx_ovr, "R9 valid kept, ovr cleared",
              {30'h0, rx_valid, rx_ovr}, 32'h2);
        check(rx_word == 24'hA1B2E5, "R9 new word", 32'(rx_word), 32'hA1B2E5);

        // R7 plain ack
        core_acknowledge();
        check(!rx_valid && !rx_ovr, "R7 ack clears", {30'h0, rx_valid, rx_ovr}, 32'h0);

        // R6 wide-access walk then low-only update
        host_write(3'd4, 8'h00, 0);
        host_write(3'd5, 8'h11, 0);
        host_write(3'd6, 8'h22, 0);
        host_write(3'd7, 8'h33, 0);
        core_acknowledge();
        host_write(3'd7, 8'h44, 0);
        check(rx_word == 24'h112244, "R6 staging retained", 32'(rx_word), 32'h112244);
        check(!rx_ovr, "R7 ack before reuse", 32'(rx_ovr), 32'h0);
        core_acknowledge();
        host_write(3'd6, 8'h55, 0);
        host_write(3'd7, 8'h66, 0);
        check(rx_word == 24'h115566, "R6 16-bit update", 32'(rx_word), 32'h115566);
        core_acknowledge();

        // mixed patterns, each acknowledged
        for (int i = 0; i < 8; i++) begin
            host_write(3'd6, 8'(i * 37 + 3), 0);
            host_write(3'd5, 8'(i * 91 + 7), 0);
            host_write(3'd7, 8'(i * 13), 0);
            core_acknowledge();
            check(!rx_valid, "R7 ack in loop", 32'(rx_valid), 32'h0);
        end

        repeat (3) @(negedge clk);
        check(pulses_seen == low_writes, "R11 pulse count", 32'(pulses_seen), 32'(low_writes));
        check(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule